// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. A 16x oversampling baud tick paces it, and an 8-bit line-setup value shapes each frame. The setup value selects:

- a data length of 5 to 8 bits;
- whether a parity bit is present, and whether it is odd, even or forced to a fixed level;
- whether one stop interval or an extended stop interval follows the data.

The line input first passes through a two-stage synchronizer. A high-to-low transition then starts a frame. The receiver re-checks the start bit at its midpoint and after that samples every bit at its centre.

The setup value is captured when the frame starts. Each received character is reported with a one-cycle valid strobe. The parity-error and framing-error flags for that character are meaningful only during the same cycle as the strobe. The data output is right-justified and zero-padded, and it keeps the last character until the next one arrives.

The control FSM has these states:

- `ST_IDLE`: waits for a line fall (`fall` → `ST_START`).
- `ST_START`: counts half a bit. A low line goes on to `ST_DATA`; a high line aborts to `ST_IDLE`.
- `ST_DATA`: takes one sample per full bit. After the last data bit it goes to `ST_PAR` when parity is on, otherwise to `ST_STOP1`.
- `ST_PAR`: samples the parity bit, then goes to `ST_STOP1`.
- `ST_STOP1`: samples the first stop bit. It goes to `ST_STOP2` when the extended stop is selected, otherwise it completes the frame and returns to `ST_IDLE`.
- `ST_STOP2`: samples the second stop interval, then completes the frame and returns to `ST_IDLE`.

Top module: `serial_frame_rx`

## Requirements
- R1: While reset is asserted and after its release, rx_valid, par_err and frm_err are 0 and rx_data is 0 until the first character completes.
- R2: line_cfg[1:0] codes 00, 01, 10, 11 select 5, 6, 7, 8 data bits. rx_data holds the character right-justified with zero upper bits, and it keeps its value between characters.
- R3: Data bits are taken least-significant first: the first bit after the start bit lands in rx_data[0].
- R4: A low pulse shorter than half a bit time (8 ticks) on an idle line produces no character.
- R5: With line_cfg[3]=1, line_cfg[4]=0 and line_cfg[5]=0, parity is odd: par_err is 1 when data bits plus parity bit hold an even number of ones.
- R6: With line_cfg[3]=1, line_cfg[4]=1 and line_cfg[5]=0, parity is even: par_err is 1 when the total number of ones is odd.
- R7: With line_cfg[3]=1 and line_cfg[5]=1, the parity bit must equal the inverse of line_cfg[4]: 0 when line_cfg[4]=1, 1 when line_cfg[4]=0. Otherwise par_err is 1.
- R8: With line_cfg[3]=0, no parity bit is expected (the bit after the data is the stop bit) and par_err stays 0.
- R9: frm_err is 1 when any checked stop sample reads 0. With line_cfg[2]=1 and a length of 6 to 8 bits, a second full stop bit is checked at its midpoint.
- R10: With line_cfg[2]=1 and a 5-bit length, the extra stop interval is half a bit long and is sampled 12 ticks after the first stop sample. A new start bit may follow right after that half bit.
- R11: rx_valid is one clock wide, and par_err and frm_err are 0 whenever rx_valid is 0.
- R12: line_cfg[7:6] have no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| line_cfg | input | 8 | Frame setup: [1:0] length, [2] stop, [3] parity on, [4] even, [5] fixed parity |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_data | output | 8 | Last received character, zero-padded |
| rx_valid | output | 1 | One-cycle character strobe |
| par_err | output | 1 | Parity mismatch, valid with rx_valid |
| frm_err | output | 1 | Stop bit read as 0, valid with rx_valid |

## Verification
Characters of every length are sent with single-bit patterns (0x01, 0x80) and with full and alternating patterns. This shows bit order, right-justification and masking of the upper bits. Each parity mode is driven once with a correct parity bit and once with an inverted one, using data whose natural parity differs from the forced level, so that odd, even, fixed-parity and no-parity checking are distinguished. Stop bits are driven low in the first, second and half-length positions, and a back-to-back pair after a half-length stop shows where that interval ends. A short low glitch shows that the start bit is re-checked.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int RX_DW = 8;
    localparam int RX_IW = $clog2(RX_DW);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic       par_fixed;
    } rx_cfg_t;

    function automatic rx_cfg_t decode_cfg(input logic [7:0] v);
        rx_cfg_t c;
        c.wlen      = v[1:0];
        c.two_stop  = v[2];
        c.par_en    = v[3];
        c.par_even  = v[4];
        c.par_fixed = v[5];
        return c;
    endfunction

    // index of the final data bit: 4 for a 5-bit word up to 7 for 8 bits
    function automatic logic [RX_IW-1:0] last_index(input logic [1:0] wlen);
        return RX_IW'(4) + RX_IW'(wlen);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic line_s,
    output logic line_fall
);
    logic [STAGES-1:0] sr_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sr_q   <= {sr_q[STAGES-2:0], din};
            prev_q <= sr_q[STAGES-1];
        end
    end

    assign line_s    = sr_q[STAGES-1];
    assign line_fall = prev_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/rx_parity_chk.sv
module rx_parity_chk import serial_rx_pkg::*; (
    input  logic [RX_DW-1:0] data,
    input  logic             par_bit,
    input  logic             par_even,
    input  logic             par_fixed,
    output logic             par_bad
);
    logic expect_bit;

    always_comb begin
        if (par_fixed)
            expect_bit = ~par_even;
        else if (par_even)
            expect_bit = ^data;
        else
            expect_bit = ~(^data);
        par_bad = (par_bit != expect_bit);
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm import serial_rx_pkg::*; #(
    parameter int OVS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             line_s,
    input  logic             line_fall,
    input  logic [7:0]       cfg_in,
    input  logic             par_bad,
    output logic [RX_DW-1:0] asm_data,
    output logic             asm_par,
    output rx_cfg_t          cfg_q,
    output logic [RX_DW-1:0] rx_data,
    output logic             rx_valid,
    output logic             par_err,
    output logic             frm_err
);
    localparam int CW       = $clog2(OVS);
    localparam int MID_LIM  = OVS / 2 - 1;      // start re-check after half a bit
    localparam int FULL_LIM = OVS - 1;          // one full bit between samples
    localparam int HALF_LIM = (OVS * 3) / 4 - 1; // rest of stop 1 plus middle of the half bit

    rx_state_e        state_q, state_d;
    logic [CW-1:0]    cnt_q, lim;
    logic [RX_IW-1:0] bit_q;
    logic             ferr_q;
    logic             hit, last_bit, done;

    always_comb begin
        unique case (state_q)
            ST_START: lim = CW'(MID_LIM);
            ST_STOP2: lim = (cfg_q.wlen == 2'd0) ? CW'(HALF_LIM) : CW'(FULL_LIM);
            default:  lim = CW'(FULL_LIM);
        endcase
    end

    assign hit      = baud_tick && (cnt_q == lim);
    assign last_bit = (bit_q == last_index(cfg_q.wlen));
    assign done     = hit && ((state_q == ST_STOP1 && !cfg_q.two_stop) || state_q == ST_STOP2);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (line_fall) state_d = ST_START;
            ST_START: if (hit) state_d = line_s ? ST_IDLE : ST_DATA;
            ST_DATA:  if (hit && last_bit) state_d = cfg_q.par_en ? ST_PAR : ST_STOP1;
            ST_PAR:   if (hit) state_d = ST_STOP1;
            ST_STOP1: if (hit) state_d = cfg_q.two_stop ? ST_STOP2 : ST_IDLE;
            ST_STOP2: if (hit) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            bit_q    <= '0;
            asm_data <= '0;
            asm_par  <= 1'b0;
            ferr_q   <= 1'b0;
            cfg_q    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
        end else begin
            if (state_q != state_d || hit) cnt_q <= '0;
            else if (baud_tick)            cnt_q <= cnt_q + 1'b1;

            if (state_q == ST_IDLE && line_fall) begin
                bit_q    <= '0;
                asm_data <= '0;
                asm_par  <= 1'b0;
                ferr_q   <= 1'b0;
                cfg_q    <= decode_cfg(cfg_in);
            end
            if (state_q == ST_DATA && hit) begin
                asm_data[bit_q] <= line_s;
                bit_q           <= bit_q + 1'b1;
            end
            if (state_q == ST_PAR && hit) asm_par <= line_s;
            if ((state_q == ST_STOP1 || state_q == ST_STOP2) && hit && !line_s) ferr_q <= 1'b1;

            rx_valid <= done;
            par_err  <= done && cfg_q.par_en && par_bad;
            frm_err  <= done && (ferr_q || !line_s);
            if (done) rx_data <= asm_data;
        end
    end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx import serial_rx_pkg::*; #(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic [7:0] line_cfg,
    input  logic       baud_tick,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       par_err,
    output logic       frm_err
);
    logic             line_s, line_fall, par_bad, asm_par;
    logic [RX_DW-1:0] asm_data;
    rx_cfg_t          cfg_q;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line),
        .line_s(line_s), .line_fall(line_fall)
    );

    rx_parity_chk u_par (
        .data(asm_data), .par_bit(asm_par), .par_even(cfg_q.par_even),
        .par_fixed(cfg_q.par_fixed), .par_bad(par_bad)
    );

    rx_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_s(line_s),
        .line_fall(line_fall), .cfg_in(line_cfg), .par_bad(par_bad),
        .asm_data(asm_data), .asm_par(asm_par), .cfg_q(cfg_q),
        .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err)
    );
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       par_enable,
    input logic [1:0] len_code,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       par_err,
    input logic       frm_err
);
    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_flags_with_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> (!par_err && !frm_err));

    p_no_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !par_enable) |-> !par_err);

    p_pad_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && len_code == 2'b00) |-> (rx_data[7:5] == 3'b000));

    p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (rx_valid || $stable(rx_data)));
endmodule

bind serial_frame_rx serial_frame_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .par_enable(line_cfg[3]), .len_code(line_cfg[1:0]),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err)
);

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] line_cfg = 8'h03;
    logic       baud_tick = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, par_err, frm_err;

    int checks = 0, bad = 0;
    int vcnt = 0, wide = 0, stray = 0;
    logic [7:0] cap_data = '0, prev_data = '0;
    logic cap_pe = 1'b0, cap_fe = 1'b0, prev_v = 1'b0;

    serial_frame_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .line_cfg(line_cfg),
        .baud_tick(baud_tick), .rx_data(rx_data), .rx_valid(rx_valid),
        .par_err(par_err), .frm_err(frm_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                vcnt      = vcnt + 1;
                prev_data = cap_data;
                cap_data  = rx_data;
                cap_pe    = par_err;
                cap_fe    = frm_err;
                if (prev_v) wide = wide + 1;
            end else if (par_err || frm_err) begin
                stray = stray + 1;
            end
            prev_v = rx_valid;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!baud_tick);
        end
    endtask

    task automatic drive(input logic v, input int n);
        @(negedge clk);
        rx_line = v;
        wait_ticks(n);
    endtask

    task automatic send_frame(input logic [7:0] cfg, input logic [7:0] d, input bit flip,
                              input bit s1, input bit s2, input int gap);
        int   n;
        logic [7:0] dm;
        logic p;
        line_cfg = cfg;
        n  = 5 + int'(cfg[1:0]);
        dm = d & 8'((1 << n) - 1);
        if (cfg[5])      p = ~cfg[4];
        else if (cfg[4]) p = ^dm;
        else             p = ~(^dm);
        drive(1'b0, 16);
        for (int i = 0; i < n; i++) drive(d[i], 16);
        if (cfg[3]) drive(p ^ flip, 16);
        drive(s1, 16);
        if (cfg[2]) drive(s2, (cfg[1:0] == 2'b00) ? 8 : 16);
        if (gap > 0) drive(1'b1, gap);
    endtask

    task automatic run_frame(input string req, input logic [7:0] cfg, input logic [7:0] d,
                             input bit flip, input bit s1, input bit s2);
        int v0, n;
        logic [7:0] exp_d;
        v0 = vcnt;
        n  = 5 + int'(cfg[1:0]);
        exp_d = d & 8'((1 << n) - 1);
        send_frame(cfg, d, flip, s1, s2, 6);
        chk(req, "strobes", vcnt - v0, 1);
        chk(req, "data", int'(cap_data), int'(exp_d));
        chk(req, "par_err", int'(cap_pe), int'(cfg[3] & flip));
        chk(req, "frm_err", int'(cap_fe), int'(!s1 || (cfg[2] && !s2)));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "valid in reset", int'(rx_valid), 0);
        chk("R1", "flags in reset", int'(par_err | frm_err), 0);
        rst_n = 1'b1;
        wait_ticks(4);
        @(negedge clk);
        chk("R1", "data after reset", int'(rx_data), 0);
        chk("R1", "valid after reset", int'(rx_valid), 0);
    endtask

    task automatic t_lengths;
        run_frame("R2", 8'h00, 8'hFF, 0, 1, 1);
        run_frame("R2", 8'h01, 8'hEA, 0, 1, 1);
        run_frame("R2", 8'h02, 8'hD5, 0, 1, 1);
        run_frame("R2", 8'h03, 8'hA5, 0, 1, 1);
    endtask

    task automatic t_order;
        run_frame("R3", 8'h03, 8'h01, 0, 1, 1);
        run_frame("R3", 8'h03, 8'h80, 0, 1, 1);
        run_frame("R3", 8'h00, 8'h10, 0, 1, 1);
    endtask

    task automatic t_glitch;
        int v0;
        v0 = vcnt;
        drive(1'b0, 3);
        drive(1'b1, 40);
        chk("R4", "strobes after glitch", vcnt - v0, 0);
        run_frame("R4", 8'h03, 8'h3C, 0, 1, 1);
    endtask

    task automatic t_parity;
        run_frame("R5", 8'h0B, 8'h07, 0, 1, 1);
        run_frame("R5", 8'h0B, 8'h07, 1, 1, 1);
        run_frame("R6", 8'h1A, 8'h33, 0, 1, 1);
        run_frame("R6", 8'h1A, 8'h33, 1, 1, 1);
        run_frame("R7", 8'h3B, 8'h01, 0, 1, 1);
        run_frame("R7", 8'h3B, 8'h01, 1, 1, 1);
        run_frame("R7", 8'h2B, 8'h03, 0, 1, 1);
        run_frame("R7", 8'h2B, 8'h03, 1, 1, 1);
    endtask

    task automatic t_nopar;
        run_frame("R8", 8'h13, 8'h5A, 0, 1, 1);
        run_frame("R8", 8'h33, 8'h01, 1, 1, 1);
    endtask

    task automatic t_stop;
        run_frame("R9", 8'h03, 8'h44, 0, 0, 1);
        run_frame("R9", 8'h06, 8'h21, 0, 1, 0);
        run_frame("R9", 8'h07, 8'h6E, 0, 0, 1);
        run_frame("R9", 8'h05, 8'h2B, 0, 1, 1);
    endtask

    task automatic t_half_stop;
        int v0;
        run_frame("R10", 8'h04, 8'h16, 0, 1, 0);
        run_frame("R10", 8'h0C, 8'h09, 0, 1, 1);
        v0 = vcnt;
        send_frame(8'h04, 8'h13, 0, 1, 1, 0);
        send_frame(8'h04, 8'h0C, 0, 1, 1, 6);
        chk("R10", "back-to-back strobes", vcnt - v0, 2);
        chk("R10", "first char", int'(prev_data), 8'h13);
        chk("R10", "second char", int'(cap_data), 8'h0C);
        chk("R10", "second frm_err", int'(cap_fe), 0);
    endtask

    task automatic t_ignored;
        run_frame("R12", 8'hC3, 8'h96, 0, 1, 1);
        run_frame("R12", 8'hCB, 8'h96, 1, 1, 1);
    endtask

    task automatic t_strobe;
        chk("R11", "wide strobes", wide, 0);
        chk("R11", "flags without strobe", stray, 0);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", checks, bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_lengths();
        t_order();
        t_glitch();
        t_parity();
        t_nopar();
        t_stop();
        t_half_stop();
        t_ignored();
        t_strobe();
        summary();
        $finish;
    end
endmodule